// File: doc/BRIEF.md
# Channel Status Serial Loader

This block takes channel-status bits for a biphase-modulated audio transmitter over a three-wire serial control bus. The bus has a chip enable, a serial clock and a data line. It keeps those bits until the modulator's block boundary, then presents them one bit per frame. All three bus wires are synchronised into the system clock domain, and the block samples on rising edges of the serial clock.

A transfer starts with an 8-bit bus address, shifted LSB first while the chip enable is low. The chip enable then goes high and frames the payload:

- a header byte, which carries a 2-bit chip identity, reserved bits and a byte-count code;
- then between 8 and 48 status bits.

Dropping the chip enable ends the transfer. A valid transfer is merged into a shadow copy. The shadow copy becomes the transmitted copy only at the next block-start frame tick. As a result, a half-finished update never reaches the stream.

The modulator sends a pulse on every frame and flags the frame that opens each 192-frame block. The block follows the frame number itself and outputs the stored bit for that frame.

Top module: `cs_status_loader`

## Requirements
- R1: A transfer is accepted only when its bus address equals 0xE9 (parameter BUS_ADDR). The address is shifted LSB first while the chip enable is low. Any other address leaves the stored and transmitted bits unchanged.
- R2: Header bits [1:0] must equal the chip identity (parameter CHIP_ID, default 1). Otherwise the transfer is discarded.
- R3: Header bits 2, 3 and 7 must be 0. A transfer with any of them set is discarded.
- R4: Header bits [6:4] give the payload length as (code+1)*8 bits for codes 0 to 5. Codes 6 and 7 discard the transfer.
- R5: The first bit after the header is status bit 0, and later bits fill ascending positions. Status bits at or above the written length keep their previous values.
- R6: A transfer that ends with fewer payload bits than its length code asks for is discarded. Bits sent beyond the length are ignored.
- R7: Accepted data becomes visible only at the first frame tick that has block start set after the chip enable falls. Several accepted transfers before that tick merge in order.
- R8: The frame index resets to 0 on a tick with block start and otherwise advances by one per tick, wrapping from 191 to 0. cs_bit_o gives the active bit at the frame index, and 0 for indices 48 to 191.
- R9: After reset every stored bit is 0, so cs_bit_o is 0 for every frame.
- R10: While the chip enable is high, one data bit is taken per rising serial clock edge. The first 8 bits form the header, LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sce_i | input | 1 | Serial chip enable; low = address phase, high = payload phase |
| sclk_i | input | 1 | Serial clock, sampled on rising edge |
| sdata_i | input | 1 | Serial data |
| frame_tick_i | input | 1 | One-cycle pulse per transmitted frame |
| block_start_i | input | 1 | Qualifies frame_tick_i as the first frame of a block |
| cs_bit_o | output | 1 | Channel-status bit for the current frame |

## Verification
Transfers are issued with full 48-bit and single-byte lengths, using distinct bit patterns. This shows whether bits land at the right index and whether bits above the length survive. Transfers with a wrong address, a wrong chip identity, set reserved bits, a reserved length code or a short payload each have to leave the output unchanged, which separates every discard path. Ticking through whole blocks before and after a block-start tick separates deferred loading from immediate loading. A block with no start flag exercises the wrap of the frame index.

// File: rtl/cs_loader_pkg.sv
package cs_loader_pkg;
  localparam int unsigned HDR_BITS = 8;
  localparam int unsigned BYTE_BITS = 8;

  // bits covered by a length code: (code+1) bytes
  function automatic int unsigned code_to_bits(input logic [2:0] code);
    return (int'(code) + 1) * BYTE_BITS;
  endfunction
endpackage

// File: rtl/cs_bus_rx.sv
module cs_bus_rx
  import cs_loader_pkg::*;
#(
  parameter logic [7:0] BUS_ADDR    = 8'hE9,
  parameter logic [1:0] CHIP_ID     = 2'd1,
  parameter int unsigned CS_BITS    = 48,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sce_i,
  input  logic                       sclk_i,
  input  logic                       sdata_i,
  output logic                       bit_we_o,
  output logic [$clog2(CS_BITS)-1:0] bit_idx_o,
  output logic                       bit_val_o,
  output logic                       commit_o,
  output logic [2:0]                 len_code_o
);
  localparam int unsigned IDX_W    = $clog2(CS_BITS);
  localparam int unsigned CNT_W    = $clog2(HDR_BITS + CS_BITS) + 1;
  localparam logic [2:0]  MAX_CODE = 3'(CS_BITS / BYTE_BITS - 1);

  logic [SYNC_STAGES-1:0] sce_s, sclk_s, sdat_s;
  logic sce_d, sclk_d;
  logic sce_now, sclk_now, sdat_now;
  logic sce_rise, sce_fall, sclk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sce_s  <= '0;
      sclk_s <= '0;
      sdat_s <= '0;
      sce_d  <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      sce_s  <= {sce_s[SYNC_STAGES-2:0], sce_i};
      sclk_s <= {sclk_s[SYNC_STAGES-2:0], sclk_i};
      sdat_s <= {sdat_s[SYNC_STAGES-2:0], sdata_i};
      sce_d  <= sce_now;
      sclk_d <= sclk_now;
    end
  end

  assign sce_now   = sce_s[SYNC_STAGES-1];
  assign sclk_now  = sclk_s[SYNC_STAGES-1];
  assign sdat_now  = sdat_s[SYNC_STAGES-1];
  assign sce_rise  = sce_now & ~sce_d;
  assign sce_fall  = ~sce_now & sce_d;
  assign sclk_rise = sclk_now & ~sclk_d;

  logic [7:0]       addr_sr, hdr_sr;
  logic             addr_hit;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] data_pos, need_cnt;
  logic             hdr_ok, take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_sr  <= '0;
      hdr_sr   <= '0;
      addr_hit <= 1'b0;
      cnt      <= '0;
    end else if (sce_rise) begin
      addr_hit <= (addr_sr == BUS_ADDR);
      cnt      <= '0;
    end else if (sclk_rise) begin
      if (!sce_now) begin
        addr_sr <= {sdat_now, addr_sr[7:1]};
      end else begin
        if (cnt < CNT_W'(HDR_BITS)) hdr_sr <= {sdat_now, hdr_sr[7:1]};
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
    end
  end

  assign len_code_o = hdr_sr[6:4];
  assign hdr_ok     = (hdr_sr[1:0] == CHIP_ID) && (hdr_sr[3:2] == 2'b00) &&
                      !hdr_sr[7] && (hdr_sr[6:4] <= MAX_CODE);
  assign need_cnt   = CNT_W'(HDR_BITS + code_to_bits(hdr_sr[6:4]));
  assign data_pos   = cnt - CNT_W'(HDR_BITS);
  assign take       = sclk_rise && sce_now && (cnt >= CNT_W'(HDR_BITS)) &&
                      (data_pos < CNT_W'(CS_BITS));

  assign bit_we_o  = take;
  assign bit_idx_o = data_pos[IDX_W-1:0];
  assign bit_val_o = sdat_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) commit_o <= 1'b0;
    else         commit_o <= sce_fall && addr_hit && hdr_ok && (cnt >= need_cnt);
  end
endmodule

// File: rtl/cs_shadow_store.sv
module cs_shadow_store
  import cs_loader_pkg::*;
#(
  parameter int unsigned CS_BITS = 48
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bit_we_i,
  input  logic [$clog2(CS_BITS)-1:0] bit_idx_i,
  input  logic                       bit_val_i,
  input  logic                       commit_i,
  input  logic [2:0]                 len_code_i,
  input  logic                       blk_load_i,
  output logic [CS_BITS-1:0]         active_o,
  output logic                       pending_o
);
  logic [CS_BITS-1:0] stage_q, shadow_q, active_q, len_mask;
  logic               pending_q;

  always_comb begin
    for (int i = 0; i < CS_BITS; i++) begin
      len_mask[i] = (i < int'(code_to_bits(len_code_i)));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else if (bit_we_i) stage_q[bit_idx_i] <= bit_val_i;
  end

  // shadow merges on commit; active copies shadow only at block start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q  <= '0;
      active_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      if (blk_load_i && pending_q) active_q <= shadow_q;
      if (commit_i) begin
        shadow_q  <= (shadow_q & ~len_mask) | (stage_q & len_mask);
        pending_q <= 1'b1;
      end else if (blk_load_i) begin
        pending_q <= 1'b0;
      end
    end
  end

  assign active_o  = active_q;
  assign pending_o = pending_q;
endmodule

// File: rtl/cs_frame_sel.sv
module cs_frame_sel #(
  parameter int unsigned CS_BITS      = 48,
  parameter int unsigned BLOCK_FRAMES = 192
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            frame_tick_i,
  input  logic                            block_start_i,
  input  logic [CS_BITS-1:0]              active_i,
  output logic [$clog2(BLOCK_FRAMES)-1:0] frame_idx_o,
  output logic                            cs_bit_o
);
  localparam int unsigned FI_W  = $clog2(BLOCK_FRAMES);
  localparam int unsigned SEL_W = $clog2(CS_BITS);

  logic [FI_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (frame_tick_i) begin
      if (block_start_i || idx_q == FI_W'(BLOCK_FRAMES - 1)) idx_q <= '0;
      else idx_q <= idx_q + 1'b1;
    end
  end

  assign frame_idx_o = idx_q;
  assign cs_bit_o    = (idx_q < FI_W'(CS_BITS)) ? active_i[idx_q[SEL_W-1:0]] : 1'b0;
endmodule

// File: rtl/cs_status_loader.sv
module cs_status_loader #(
  parameter logic [7:0]  BUS_ADDR     = 8'hE9,
  parameter logic [1:0]  CHIP_ID      = 2'd1,
  parameter int unsigned CS_BITS      = 48,
  parameter int unsigned BLOCK_FRAMES = 192,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sce_i,
  input  logic sclk_i,
  input  logic sdata_i,
  input  logic frame_tick_i,
  input  logic block_start_i,
  output logic cs_bit_o
);
  localparam int unsigned IDX_W = $clog2(CS_BITS);
  localparam int unsigned FI_W  = $clog2(BLOCK_FRAMES);

  logic             bit_we_w, bit_val_w, commit_w, pending_w;
  logic [IDX_W-1:0] bit_idx_w;
  logic [2:0]       len_code_w;
  logic [CS_BITS-1:0] active_w;
  logic [FI_W-1:0]  frame_idx_w;

  cs_bus_rx #(
    .BUS_ADDR(BUS_ADDR), .CHIP_ID(CHIP_ID),
    .CS_BITS(CS_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk_i, .rst_ni, .sce_i, .sclk_i, .sdata_i,
    .bit_we_o(bit_we_w), .bit_idx_o(bit_idx_w), .bit_val_o(bit_val_w),
    .commit_o(commit_w), .len_code_o(len_code_w)
  );

  cs_shadow_store #(.CS_BITS(CS_BITS)) u_store (
    .clk_i, .rst_ni,
    .bit_we_i(bit_we_w), .bit_idx_i(bit_idx_w), .bit_val_i(bit_val_w),
    .commit_i(commit_w), .len_code_i(len_code_w),
    .blk_load_i(frame_tick_i & block_start_i),
    .active_o(active_w), .pending_o(pending_w)
  );

  cs_frame_sel #(.CS_BITS(CS_BITS), .BLOCK_FRAMES(BLOCK_FRAMES)) u_sel (
    .clk_i, .rst_ni, .frame_tick_i, .block_start_i,
    .active_i(active_w), .frame_idx_o(frame_idx_w), .cs_bit_o
  );
endmodule

// File: rtl/cs_status_loader_chk.sv
module cs_status_loader_chk #(
  parameter int unsigned CS_BITS      = 48,
  parameter int unsigned BLOCK_FRAMES = 192
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            frame_tick_i,
  input logic                            block_start_i,
  input logic                            cs_bit_o,
  input logic                            commit_i,
  input logic                            pending_i,
  input logic [2:0]                      len_code_i,
  input logic [CS_BITS-1:0]              active_i,
  input logic [$clog2(BLOCK_FRAMES)-1:0] frame_idx_i
);
  localparam int unsigned FI_W = $clog2(BLOCK_FRAMES);
  localparam logic [2:0] MAX_CODE = 3'(CS_BITS / 8 - 1);

  // R7
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_tick_i && block_start_i) |=> $stable(active_i));

  // R7
  load_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_tick_i && block_start_i && !commit_i) |=> !pending_i);

  // R8
  blk_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_tick_i && block_start_i) |=> (frame_idx_i == '0));

  // R8
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_tick_i |=> $stable(frame_idx_i));

  // R8
  hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_idx_i >= FI_W'(CS_BITS)) |-> !cs_bit_o);

  // R4
  commit_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (len_code_i <= MAX_CODE));
endmodule

bind cs_status_loader cs_status_loader_chk #(
  .CS_BITS(CS_BITS), .BLOCK_FRAMES(BLOCK_FRAMES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_tick_i(frame_tick_i),
  .block_start_i(block_start_i), .cs_bit_o(cs_bit_o),
  .commit_i(commit_w), .pending_i(pending_w), .len_code_i(len_code_w),
  .active_i(active_w), .frame_idx_i(frame_idx_w)
);

// File: tb/test_cs_status_loader.sv
module test_cs_status_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sce = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic tick = 1'b0, bstart = 1'b0;
  logic cs_bit;

  always #5 clk = ~clk;

  cs_status_loader i_cs_status_loader (
    .clk_i(clk), .rst_ni(rst_n), .sce_i(sce), .sclk_i(sclk), .sdata_i(sdat),
    .frame_tick_i(tick), .block_start_i(bstart), .cs_bit_o(cs_bit)
  );

  int checks = 0, fails = 0;
  bit done = 0, cmp_en = 0;
  string cur_req = "R9";

  // reference model
  logic [47:0] m_active = '0, m_shadow = '0;
  bit m_pending = 0;
  int m_idx = 0;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: cs_bit actual=%0b expected=%0b (frame %0d, t=%0t)",
               req, act, exp, m_idx, $time);
    end
  endtask

  function automatic logic model_bit();
    return (m_idx < 48) ? m_active[m_idx] : 1'b0;
  endfunction

  always @(posedge clk) begin
    #3;
    if (cmp_en) check(cur_req, cs_bit, model_bit());
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdat = b; wait_clk(4);
    sclk = 1'b1; wait_clk(4);
    sclk = 1'b0;
  endtask

  // address LSB first with CE low, then header + payload with CE high
  task automatic xfer(input logic [7:0] addr, input logic [7:0] hdr,
                      input int nbits, input logic [63:0] data);
    int need;
    logic [47:0] mask;
    for (int i = 0; i < 8; i++) sbit(addr[i]);
    wait_clk(4); sce = 1'b1; wait_clk(4);
    for (int i = 0; i < 8; i++) sbit(hdr[i]);
    for (int i = 0; i < nbits; i++) sbit(data[i]);
    wait_clk(4); sce = 1'b0; wait_clk(10);
    need = (int'(hdr[6:4]) + 1) * 8;
    if (addr == 8'hE9 && hdr[1:0] == 2'd1 && hdr[3:2] == 2'b00 && !hdr[7] &&
        hdr[6:4] <= 3'd5 && nbits >= need) begin
      mask = '0;
      for (int i = 0; i < need; i++) mask[i] = 1'b1;
      m_shadow = (m_shadow & ~mask) | (data[47:0] & mask);
      m_pending = 1;
    end
  endtask

  task automatic do_tick(input bit blk);
    @(negedge clk); tick = 1'b1; bstart = blk;
    @(posedge clk); #1;
    if (blk) begin
      m_idx = 0;
      if (m_pending) begin m_active = m_shadow; m_pending = 0; end
    end else m_idx = (m_idx == 191) ? 0 : m_idx + 1;
    @(negedge clk); tick = 1'b0; bstart = 1'b0;
  endtask

  task automatic run_block(input bit blk);
    do_tick(blk);
    for (int i = 1; i < 192; i++) do_tick(1'b0);
  endtask

  initial begin
    wait_clk(3); rst_n = 1'b1; wait_clk(2);
    cmp_en = 1;
    cur_req = "R9"; check("R9", cs_bit, 1'b0);
    run_block(1);

    // full 48-bit write: deferred to block start
    cur_req = "R7";
    xfer(8'hE9, 8'h51, 48, 64'h0000_A5C3_9F0E_7B12);
    run_block(0);
    cur_req = "R8"; run_block(1);
    cur_req = "R10"; run_block(1);

    // one-byte write keeps upper bits
    cur_req = "R5";
    xfer(8'hE9, 8'h01, 8, 64'h0000_0000_0000_00E6);
    run_block(1);

    cur_req = "R4";
    xfer(8'hE9, 8'h21, 24, 64'h0000_0000_0012_3456);
    run_block(1);

    cur_req = "R1";
    xfer(8'hE8, 8'h51, 48, 64'h0000_FFFF_FFFF_FFFF);
    run_block(1);

    cur_req = "R2";
    xfer(8'hE9, 8'h52, 48, 64'h0000_FFFF_FFFF_FFFF);
    xfer(8'hE9, 8'h50, 48, 64'h0000_FFFF_FFFF_FFFF);
    run_block(1);

    cur_req = "R3";
    xfer(8'hE9, 8'h09, 8, 64'hFF);
    xfer(8'hE9, 8'h05, 8, 64'hFF);
    xfer(8'hE9, 8'h81, 8, 64'hFF);
    run_block(1);

    cur_req = "R4";
    xfer(8'hE9, 8'h61, 48, 64'h0000_FFFF_FFFF_FFFF);
    xfer(8'hE9, 8'h71, 48, 64'h0000_FFFF_FFFF_FFFF);
    run_block(1);

    cur_req = "R6";
    xfer(8'hE9, 8'h21, 20, 64'hF_FFFF);
    run_block(1);
    xfer(8'hE9, 8'h11, 24, 64'h00FF_3C5A);
    run_block(1);

    // two writes merge before load
    cur_req = "R7";
    xfer(8'hE9, 8'h51, 48, 64'h0000_1111_2222_3333);
    xfer(8'hE9, 8'h11, 16, 64'h0000_0000_0000_ABCD);
    run_block(0);
    run_block(1);

    // index wraps without a block flag
    cur_req = "R8";
    run_block(0);
    run_block(1);

    done = 1;
    cmp_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule